// File: doc/BRIEF.md
# Result Saturation and Sticky Status Unit

This block sits behind the arithmetic of a fixed-point geometry pipeline. Each destination register of that pipeline has a strobe and a raw, wider-than-needed result input. The unit clamps or wraps every raw value to its destination's legal range and returns the fitted value combinationally, in the same cycle. When a strobed value had to be fitted, the unit raises a status bit for that destination. The block does no arithmetic and keeps none of the destination registers. It owns only the status word.

The status word is sticky. A bit stays set until the clear strobe arrives, and a host may overwrite its writable field. Bit 31 is a summary error bit. It is derived combinationally from a fixed subset of the other bits, so some flags count as errors and others, such as the third intermediate lane, the colour bits and the depth-cue bit, count only as warnings.

The unit has no states. A flag update is one registered step: a strobe in cycle N is visible in the status word after the clock edge that ends cycle N.

Top module: `sat_flag_unit`

## Requirements
- R1: Accumulator lanes 0..3 output the low 32 bits of their 64-bit signed input. A strobed value above 2^31-1 sets overflow bit 16 (lane 0) or bit 30/29/28 (lanes 1/2/3).
- R2: A strobed accumulator value below -2^31 sets underflow bit 15 (lane 0) or bit 27/26/25 (lanes 1/2/3). The output stays the low 32 bits.
- R3: Intermediate lanes 1..3 clamp a 32-bit signed input to -32768..32767. A strobed clamp sets bit 24/23/22.
- R4: With a lane's limit-mode bit set, its lower bound becomes 0 instead of -32768.
- R5: The depth-cue lane clamps to 0..0x1000, and a strobed clamp sets bit 12.
- R6: Screen X and screen Y each clamp to -0x400..+0x3FF, with outputs as 16-bit two's complement. A strobed clamp sets bit 14 (X) or bit 13 (Y).
- R7: Screen Z clamps to 0..0xFFFF, and a strobed clamp sets bit 18.
- R8: A 32-bit unsigned quotient above 0x1FFFF is output as 0x1FFFF, and a strobed clamp sets bit 17.
- R9: Flags appear one clock edge after their strobe and stay set on later edges. An out-of-range value without its strobe is still fitted but sets no flag.
- R10: The clear strobe empties the status word on the next edge, and it overrides both a host write and any set in the same cycle.
- R11: A host write keeps only bits 30:12 of its data. Bits 11:0 always read 0. Sets in the same cycle are ORed onto the written value.
- R12: Bit 31 reads as the OR of bits 30..23 and 18..13 (mask 0x7F87E000). Bits 22, 21..19 (colour) and 12 do not affect it.
- R13: After reset the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_vld | input | 4 | Per-lane accumulator strobe, bit i = lane i |
| mac_raw | input | 4x64 | Accumulator raw results, signed |
| mac_out | output | 4x32 | Accumulator fitted values |
| ir_vld | input | 3 | Intermediate lane strobes, bit 0 = lane 1 |
| ir_lm | input | 3 | Limit-mode bits per intermediate lane |
| ir_raw | input | 3x32 | Intermediate raw values, signed |
| ir_out | output | 3x16 | Intermediate clamped values |
| ir0_vld | input | 1 | Depth-cue strobe |
| ir0_raw | input | 32 | Depth-cue raw value, signed |
| ir0_out | output | 16 | Depth-cue clamped value |
| sxy_vld | input | 1 | Screen X/Y push strobe |
| sx_raw | input | 32 | Screen X raw, signed |
| sy_raw | input | 32 | Screen Y raw, signed |
| sx_out | output | 16 | Screen X clamped |
| sy_out | output | 16 | Screen Y clamped |
| sz_vld | input | 1 | Screen Z push strobe |
| sz_raw | input | 32 | Screen Z raw, signed |
| sz_out | output | 16 | Screen Z clamped, unsigned |
| div_vld | input | 1 | Quotient check strobe |
| div_raw | input | 32 | Quotient, unsigned |
| div_out | output | 17 | Quotient clamped |
| flag_clr | input | 1 | Clear the status word |
| host_wr | input | 1 | Host write strobe for the status word |
| host_wdata | input | 32 | Host write data |
| flag_word | output | 32 | Status word, also the host read value |

## Verification
The properties take every input to be a known value in each cycle after reset. They also assume that flag_clr and host_wr are the only ways, other than strobes, for the status word to change. The overflow property on accumulator lane 1 additionally assumes that no clear is pending in the cycle it watches. The stimulus holds every input at a defined level from time zero, changes inputs only at falling edges, and drops all strobes between vectors. It also issues a clear before each table vector, so the window each property watches contains exactly one cause of change.

// File: rtl/sat_flag_pkg.sv
package sat_flag_pkg;

    localparam int FLAG_W      = 32;
    localparam int STORE_W     = FLAG_W - 1;
    localparam int ERR_POS     = 31;

    localparam logic [FLAG_W-1:0] HOST_KEEP = 32'h7FFF_F000;
    localparam logic [FLAG_W-1:0] ERR_SET   = 32'h7F87_E000;

    localparam int MAC_LANES = 4;
    localparam int IR_LANES  = 3;

    localparam int MAC_OVF_POS [MAC_LANES] = '{16, 30, 29, 28};
    localparam int MAC_UNF_POS [MAC_LANES] = '{15, 27, 26, 25};
    localparam int IR_SAT_POS  [IR_LANES]  = '{24, 23, 22};

    localparam int SZ_POS  = 18;
    localparam int DIV_POS = 17;
    localparam int SX_POS  = 14;
    localparam int SY_POS  = 13;
    localparam int IR0_POS = 12;

    localparam longint IR_HI   = 32767;
    localparam longint IR_LO   = -32768;
    localparam longint IR0_HI  = 4096;
    localparam longint SXY_HI  = 1023;
    localparam longint SXY_LO  = -1024;
    localparam longint SZ_HI   = 65535;
    localparam longint DIV_HI  = 131071;

endpackage

// File: rtl/mac_wrap.sv
module mac_wrap #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] val,
    output logic             ovf,
    output logic             unf
);
    localparam int TOP = IN_W - 2;
    localparam int BOT = OUT_W - 1;

    logic sign_bit;
    logic any_one;
    logic all_one;

    assign sign_bit = raw[IN_W-1];
    assign any_one  = |raw[TOP:BOT];
    assign all_one  = &raw[TOP:BOT];

    assign val = raw[OUT_W-1:0];
    assign ovf = !sign_bit && any_one;
    assign unf = sign_bit && !all_one;
endmodule

// File: rtl/range_clamp.sv
module range_clamp #(
    parameter int     IN_W   = 32,
    parameter int     OUT_W  = 16,
    parameter longint HI     = 32767,
    parameter longint LO     = -32768,
    parameter longint LO_ALT = 0
) (
    input  logic [IN_W-1:0]  raw,
    input  logic             use_alt,
    output logic [OUT_W-1:0] val,
    output logic             hit
);
    localparam logic signed [63:0] HI_S  = 64'(HI);
    localparam logic signed [63:0] LO_S  = 64'(LO);
    localparam logic signed [63:0] ALT_S = 64'(LO_ALT);

    logic signed [63:0] wide;
    logic signed [63:0] lo_sel;

    assign wide   = {{(64-IN_W){raw[IN_W-1]}}, raw};
    assign lo_sel = use_alt ? ALT_S : LO_S;

    always_comb begin
        if (wide > HI_S) begin
            val = HI_S[OUT_W-1:0];
            hit = 1'b1;
        end else if (wide < lo_sel) begin
            val = lo_sel[OUT_W-1:0];
            hit = 1'b1;
        end else begin
            val = wide[OUT_W-1:0];
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int             W    = 31,
    parameter logic [W-1:0]   KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (wr) begin
            q <= (wdata | set) & KEEP;
        end else begin
            q <= q | (set & KEEP);
        end
    end
endmodule

// File: rtl/sat_flag_unit.sv
module sat_flag_unit
    import sat_flag_pkg::*;
#(
    parameter int MAC_IN_W = 64,
    parameter int REG_W    = 32,
    parameter int IN_W     = 32,
    parameter int IR_W     = 16,
    parameter int DIV_W    = 17
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [MAC_LANES-1:0]               mac_vld,
    input  logic [MAC_LANES-1:0][MAC_IN_W-1:0] mac_raw,
    output logic [MAC_LANES-1:0][REG_W-1:0]    mac_out,
    input  logic [IR_LANES-1:0]                ir_vld,
    input  logic [IR_LANES-1:0]                ir_lm,
    input  logic [IR_LANES-1:0][IN_W-1:0]      ir_raw,
    output logic [IR_LANES-1:0][IR_W-1:0]      ir_out,
    input  logic                               ir0_vld,
    input  logic [IN_W-1:0]                    ir0_raw,
    output logic [IR_W-1:0]                    ir0_out,
    input  logic                               sxy_vld,
    input  logic [IN_W-1:0]                    sx_raw,
    input  logic [IN_W-1:0]                    sy_raw,
    output logic [IR_W-1:0]                    sx_out,
    output logic [IR_W-1:0]                    sy_out,
    input  logic                               sz_vld,
    input  logic [IN_W-1:0]                    sz_raw,
    output logic [IR_W-1:0]                    sz_out,
    input  logic                               div_vld,
    input  logic [IN_W-1:0]                    div_raw,
    output logic [DIV_W-1:0]                   div_out,
    input  logic                               flag_clr,
    input  logic                               host_wr,
    input  logic [FLAG_W-1:0]                  host_wdata,
    output logic [FLAG_W-1:0]                  flag_word
);
    localparam int DIV_IN_W = IN_W + 1;

    logic [MAC_LANES-1:0] m_ovf;
    logic [MAC_LANES-1:0] m_unf;
    logic [IR_LANES-1:0]  ir_hit;
    logic                 ir0_hit;
    logic                 sx_hit;
    logic                 sy_hit;
    logic                 sz_hit;
    logic                 div_hit;
    logic [STORE_W-1:0]   set_vec;
    logic [STORE_W-1:0]   store_q;

    // accumulator lanes: wrap to the low word, report direction of escape
    for (genvar g = 0; g < MAC_LANES; g++) begin : g_mac
        mac_wrap #(
            .IN_W  (MAC_IN_W),
            .OUT_W (REG_W)
        ) u_wrap (
            .raw (mac_raw[g]),
            .val (mac_out[g]),
            .ovf (m_ovf[g]),
            .unf (m_unf[g])
        );
    end

    // intermediate lanes: signed clamp with a switchable lower bound
    for (genvar g = 0; g < IR_LANES; g++) begin : g_ir
        range_clamp #(
            .IN_W   (IN_W),
            .OUT_W  (IR_W),
            .HI     (IR_HI),
            .LO     (IR_LO),
            .LO_ALT (0)
        ) u_clamp (
            .raw     (ir_raw[g]),
            .use_alt (ir_lm[g]),
            .val     (ir_out[g]),
            .hit     (ir_hit[g])
        );
    end

    range_clamp #(
        .IN_W (IN_W), .OUT_W (IR_W), .HI (IR0_HI), .LO (0), .LO_ALT (0)
    ) u_ir0 (
        .raw (ir0_raw), .use_alt (1'b0), .val (ir0_out), .hit (ir0_hit)
    );

    range_clamp #(
        .IN_W (IN_W), .OUT_W (IR_W), .HI (SXY_HI), .LO (SXY_LO), .LO_ALT (SXY_LO)
    ) u_sx (
        .raw (sx_raw), .use_alt (1'b0), .val (sx_out), .hit (sx_hit)
    );

    range_clamp #(
        .IN_W (IN_W), .OUT_W (IR_W), .HI (SXY_HI), .LO (SXY_LO), .LO_ALT (SXY_LO)
    ) u_sy (
        .raw (sy_raw), .use_alt (1'b0), .val (sy_out), .hit (sy_hit)
    );

    range_clamp #(
        .IN_W (IN_W), .OUT_W (IR_W), .HI (SZ_HI), .LO (0), .LO_ALT (0)
    ) u_sz (
        .raw (sz_raw), .use_alt (1'b0), .val (sz_out), .hit (sz_hit)
    );

    // quotient is unsigned: a zero guard bit keeps it non-negative
    range_clamp #(
        .IN_W (DIV_IN_W), .OUT_W (DIV_W), .HI (DIV_HI), .LO (0), .LO_ALT (0)
    ) u_div (
        .raw ({1'b0, div_raw}), .use_alt (1'b0), .val (div_out), .hit (div_hit)
    );

    // gather this cycle's flag sets, qualified by their strobes
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < MAC_LANES; i++) begin
            if (mac_vld[i] && m_ovf[i]) set_vec[MAC_OVF_POS[i]] = 1'b1;
            if (mac_vld[i] && m_unf[i]) set_vec[MAC_UNF_POS[i]] = 1'b1;
        end
        for (int i = 0; i < IR_LANES; i++) begin
            if (ir_vld[i] && ir_hit[i]) set_vec[IR_SAT_POS[i]] = 1'b1;
        end
        if (ir0_vld && ir0_hit) set_vec[IR0_POS] = 1'b1;
        if (sxy_vld && sx_hit)  set_vec[SX_POS]  = 1'b1;
        if (sxy_vld && sy_hit)  set_vec[SY_POS]  = 1'b1;
        if (sz_vld && sz_hit)   set_vec[SZ_POS]  = 1'b1;
        if (div_vld && div_hit) set_vec[DIV_POS] = 1'b1;
    end

    sticky_flags #(
        .W    (STORE_W),
        .KEEP (HOST_KEEP[STORE_W-1:0])
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flag_clr),
        .wr    (host_wr),
        .wdata (host_wdata[STORE_W-1:0]),
        .set   (set_vec),
        .q     (store_q)
    );

    assign flag_word = {|(store_q & ERR_SET[STORE_W-1:0]), store_q};
endmodule

// File: rtl/sat_flag_chk.sv
module sat_flag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mac1_vld,
    input logic [63:0] mac1_raw,
    input logic        lm1,
    input logic [15:0] ir1_out,
    input logic [15:0] ir0_out,
    input logic [15:0] sx_out,
    input logic [15:0] sy_out,
    input logic        flag_clr,
    input logic        host_wr,
    input logic [31:0] flag_word
);
    // R1: a strobed lane-1 overflow shows in bit 30 and in the summary bit
    p_mac1_ovf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mac1_vld && !flag_clr && !mac1_raw[63] && (|mac1_raw[62:31]))
        |=> (flag_word[30] && flag_word[31]));

    // R4: limit mode never yields a negative intermediate value
    p_lm_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lm1 |-> !ir1_out[15]);

    // R5: depth-cue output stays within 0..0x1000
    p_ir0_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ir0_out <= 16'h1000);

    // R6: screen coordinates stay within -0x400..+0x3FF
    p_sx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(sx_out) >= -16'sd1024) && ($signed(sx_out) <= 16'sd1023));
    p_sy_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(sy_out) >= -16'sd1024) && ($signed(sy_out) <= 16'sd1023));

    // R9: without clear or write, no set bit is lost
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && !host_wr)
        |=> ((flag_word & $past(flag_word)) == $past(flag_word)));

    // R10: clear empties the word on the next edge
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (flag_word == 32'h0));

    // R11: the low field never reads non-zero
    p_low_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word[11:0] == 12'h0);
endmodule

bind sat_flag_unit sat_flag_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mac1_vld  (mac_vld[1]),
    .mac1_raw  (mac_raw[1]),
    .lm1       (ir_lm[0]),
    .ir1_out   (ir_out[0]),
    .ir0_out   (ir0_out),
    .sx_out    (sx_out),
    .sy_out    (sy_out),
    .flag_clr  (flag_clr),
    .host_wr   (host_wr),
    .flag_word (flag_word)
);

// File: tb/sim_sat_flag_unit.sv
`timescale 1ns/1ps
module sim_sat_flag_unit;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [3:0]            mac_vld = '0;
    logic [3:0][63:0]      mac_raw = '0;
    logic [3:0][31:0]      mac_out;
    logic [2:0]            ir_vld = '0;
    logic [2:0]            ir_lm = '0;
    logic [2:0][31:0]      ir_raw = '0;
    logic [2:0][15:0]      ir_out;
    logic                  ir0_vld = 1'b0;
    logic [31:0]           ir0_raw = '0;
    logic [15:0]           ir0_out;
    logic                  sxy_vld = 1'b0;
    logic [31:0]           sx_raw = '0;
    logic [31:0]           sy_raw = '0;
    logic [15:0]           sx_out;
    logic [15:0]           sy_out;
    logic                  sz_vld = 1'b0;
    logic [31:0]           sz_raw = '0;
    logic [15:0]           sz_out;
    logic                  div_vld = 1'b0;
    logic [31:0]           div_raw = '0;
    logic [16:0]           div_out;
    logic                  flag_clr = 1'b0;
    logic                  host_wr = 1'b0;
    logic [31:0]           host_wdata = '0;
    logic [31:0]           flag_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sat_flag_unit u0 (.*);

    typedef struct packed {
        logic [3:0]  sel;   // 0..3 acc lane, 4..6 IR1..3, 7 depth, 8 X, 9 Y, 10 Z, 11 quotient
        logic [63:0] raw;
        logic        lm;
        logic [31:0] val;
        logic [31:0] flg;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  64'h0000_0000_7FFF_FFFF, 1'b0, 32'h7FFF_FFFF, 32'h0000_0000}, // R1 top edge
        '{4'd1,  64'h0000_0000_8000_0000, 1'b0, 32'h8000_0000, 32'hC000_0000}, // R1 overflow
        '{4'd2,  64'hFFFF_FFFF_8000_0000, 1'b0, 32'h8000_0000, 32'h0000_0000}, // R2 bottom edge
        '{4'd2,  64'hFFFF_FFFF_7FFF_FFFF, 1'b0, 32'h7FFF_FFFF, 32'h8400_0000}, // R2 underflow
        '{4'd3,  64'h0000_0001_0000_0005, 1'b0, 32'h0000_0005, 32'h9000_0000}, // R1 lane 3
        '{4'd0,  64'h0000_0001_0000_0000, 1'b0, 32'h0000_0000, 32'h8001_0000}, // R1 lane 0
        '{4'd0,  64'hFFFF_FFFE_0000_0000, 1'b0, 32'h0000_0000, 32'h8000_8000}, // R2 lane 0
        '{4'd4,  64'h0000_0000_0000_7FFF, 1'b0, 32'h0000_7FFF, 32'h0000_0000}, // R3 edge
        '{4'd4,  64'h0000_0000_0000_8000, 1'b0, 32'h0000_7FFF, 32'h8100_0000}, // R3 high
        '{4'd5,  64'h0000_0000_FFFF_7FFF, 1'b0, 32'h0000_8000, 32'h8080_0000}, // R3 low
        '{4'd5,  64'h0000_0000_FFFF_FFFB, 1'b1, 32'h0000_0000, 32'h8080_0000}, // R4 limit
        '{4'd6,  64'h0000_0000_FFFF_FFFF, 1'b0, 32'h0000_FFFF, 32'h0000_0000}, // R3 minus one
        '{4'd6,  64'h0000_0000_0001_0000, 1'b0, 32'h0000_7FFF, 32'h0040_0000}, // R3 lane 3, R12 no error
        '{4'd7,  64'h0000_0000_0000_1000, 1'b0, 32'h0000_1000, 32'h0000_0000}, // R5 edge
        '{4'd7,  64'h0000_0000_0000_1001, 1'b0, 32'h0000_1000, 32'h0000_1000}, // R5 high
        '{4'd7,  64'h0000_0000_FFFF_FFFF, 1'b0, 32'h0000_0000, 32'h0000_1000}, // R5 low
        '{4'd8,  64'h0000_0000_0000_03FF, 1'b0, 32'h0000_03FF, 32'h0000_0000}, // R6 edge
        '{4'd8,  64'h0000_0000_0000_0400, 1'b0, 32'h0000_03FF, 32'h8000_4000}, // R6 X high
        '{4'd9,  64'h0000_0000_FFFF_FBFF, 1'b0, 32'h0000_FC00, 32'h8000_2000}, // R6 Y low
        '{4'd10, 64'h0000_0000_0000_FFFF, 1'b0, 32'h0000_FFFF, 32'h0000_0000}, // R7 edge
        '{4'd10, 64'h0000_0000_0001_0000, 1'b0, 32'h0000_FFFF, 32'h8004_0000}, // R7 high
        '{4'd10, 64'h0000_0000_FFFF_FFFD, 1'b0, 32'h0000_0000, 32'h8004_0000}, // R7 low
        '{4'd11, 64'h0000_0000_0001_FFFF, 1'b0, 32'h0001_FFFF, 32'h0000_0000}, // R8 edge
        '{4'd11, 64'h0000_0000_0002_0000, 1'b0, 32'h0001_FFFF, 32'h8002_0000}  // R8 high
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] sel, input logic lm);
        if (sel <= 4'd3) return "R1/R2";
        if (sel <= 4'd6) return lm ? "R4" : "R3";
        if (sel == 4'd7) return "R5";
        if (sel <= 4'd9) return "R6";
        if (sel == 4'd10) return "R7";
        return "R8";
    endfunction

    task automatic idle();
        mac_vld = '0; ir_vld = '0; ir_lm = '0; ir0_vld = 1'b0;
        sxy_vld = 1'b0; sz_vld = 1'b0; div_vld = 1'b0;
        sx_raw = '0; sy_raw = '0; host_wr = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        idle();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic drive(input vec_t v);
        case (v.sel)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                mac_vld[v.sel[1:0]] = 1'b1; mac_raw[v.sel[1:0]] = v.raw;
            end
            4'd4, 4'd5, 4'd6: begin
                ir_vld[v.sel - 4'd4] = 1'b1; ir_lm[v.sel - 4'd4] = v.lm;
                ir_raw[v.sel - 4'd4] = v.raw[31:0];
            end
            4'd7:  begin ir0_vld = 1'b1; ir0_raw = v.raw[31:0]; end
            4'd8:  begin sxy_vld = 1'b1; sx_raw = v.raw[31:0]; end
            4'd9:  begin sxy_vld = 1'b1; sy_raw = v.raw[31:0]; end
            4'd10: begin sz_vld = 1'b1; sz_raw = v.raw[31:0]; end
            default: begin div_vld = 1'b1; div_raw = v.raw[31:0]; end
        endcase
    endtask

    function automatic logic [31:0] read_val(input logic [3:0] sel);
        case (sel)
            4'd0, 4'd1, 4'd2, 4'd3: return mac_out[sel[1:0]];
            4'd4:  return {16'h0, ir_out[0]};
            4'd5:  return {16'h0, ir_out[1]};
            4'd6:  return {16'h0, ir_out[2]};
            4'd7:  return {16'h0, ir0_out};
            4'd8:  return {16'h0, sx_out};
            4'd9:  return {16'h0, sy_out};
            4'd10: return {16'h0, sz_out};
            default: return {15'h0, div_out};
        endcase
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R13 reset word", flag_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 after release", flag_word, 32'h0);

        for (int i = 0; i < NV; i++) begin
            clear_flags();
            drive(TBL[i]);
            #1;
            check({req_of(TBL[i].sel, TBL[i].lm), " value"}, read_val(TBL[i].sel), TBL[i].val);
            @(negedge clk);
            idle();
            check({req_of(TBL[i].sel, TBL[i].lm), " flags (R12 summary)"}, flag_word, TBL[i].flg);
        end

        // R9: value still clamped without strobe, but no flag
        clear_flags();
        ir_raw[0] = 32'h0001_0000;
        #1;
        check("R9 unstrobed value", {16'h0, ir_out[0]}, 32'h0000_7FFF);
        @(negedge clk);
        check("R9 unstrobed flag", flag_word, 32'h0);

        // R9: sticky across a clean strobe
        ir_vld[0] = 1'b1;
        @(negedge clk);
        idle();
        mac_vld[1] = 1'b1; mac_raw[1] = 64'h5;
        @(negedge clk);
        idle();
        @(negedge clk);
        check("R9 sticky", flag_word, 32'h8100_0000);

        // R10: clear beats write and sets in the same cycle
        flag_clr = 1'b1; host_wr = 1'b1; host_wdata = 32'hFFFF_FFFF; ir_vld[0] = 1'b1;
        @(negedge clk);
        idle();
        check("R10 clear priority", flag_word, 32'h0);

        // R11/R12: full write keeps 30:12, summary recomputed
        host_wr = 1'b1; host_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        idle();
        check("R11 write mask", flag_word, 32'hFFFF_F000);

        // R12: warning-only bits leave the summary clear
        host_wr = 1'b1; host_wdata = 32'h0078_1000;
        @(negedge clk);
        idle();
        check("R12 warning bits", flag_word, 32'h0078_1000);

        // R11: low field is dropped
        host_wr = 1'b1; host_wdata = 32'h0000_0FFF;
        @(negedge clk);
        idle();
        check("R11 low field", flag_word, 32'h0);

        // R11: set ORed onto a same-cycle write
        host_wr = 1'b1; host_wdata = 32'h0010_0000;
        ir_vld[0] = 1'b1; ir_raw[0] = 32'h0001_0000;
        @(negedge clk);
        idle();
        check("R11 write plus set", flag_word, 32'h8110_0000);

        finish_run();
    end
endmodule